// File: doc/BRIEF.md
# Virtualization Control-Structure Pointer Controller

This block carries out the root-mode management commands of a hardware virtualization unit. The seven commands are: switch virtualization on, switch it off, load the current pointer, store the current pointer, clear a structure, launch and resume. Across commands it keeps three pieces of state:

- whether the core is in virtualization mode;
- the current control-structure pointer;
- a small table that records, for each structure page, whether it is clear or launched.

Each command arrives as a one-cycle strobe. It carries a 64-bit operand address, the current privilege level, mode flags, and the 32-bit revision word that the memory pipeline has already fetched from that address.

The controller checks fault conditions in a fixed priority order and returns one outcome code and the six arithmetic flags that go with it. Memory access, the guest-state consistency checks and the system-management monitor path are outside the block. The consistency checks arrive as one pass/fail input. The command port has no ready signal: a command is accepted on every cycle and its result always returns on the next cycle, so there is no back-pressure. The result pins are plain status outputs.

Top module: `vcsp_ctrl`

## Requirements

- R1: Command timing.
  - A command strobed on `cmd_valid` at one clock edge produces `rsp_valid`=1 for exactly the following cycle.
  - `rsp_valid` is 0 in every cycle that does not follow a strobe.
  - After reset, `rsp_valid`, `mode_on` and `err_field` are 0.
- R2: Command and outcome codes, and their priority.
  - Command codes: 0 enable, 1 disable, 2 load, 3 store, 4 clear, 5 launch, 6 resume, 7 reserved.
  - Outcome codes: 0 OK, 1 fail-invalid, 2 fail-valid, 3 undefined-opcode, 4 privilege fault, 5 exit to monitor.
  - Undefined-opcode is reported when any of these holds: the command is code 7; `cmd_legacy` is 1; the command is enable and `cmd_feat_en` is 0; the command is anything other than enable while `mode_on` is 0.
  - Otherwise, exit is reported when in mode with `cmd_nonroot`=1.
  - Otherwise, a privilege fault is reported when `cmd_cpl` is not 0.
  - Only after all of these are the command's own checks applied.
- R3: Flag vector, with bit 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF.
  - OK gives 6'b000000.
  - Fail-invalid gives 6'b000001.
  - Fail-valid gives 6'b001000.
  - The three fault outcomes give 6'b000000.
- R4: Generic command failure.
  - When the current pointer is valid (not all ones), a failing check gives fail-valid and writes its error number into `err_field`.
  - When the pointer is invalid, the same failing check gives fail-invalid.
  - `err_field` changes only on fail-valid.
- R5: Enable.
  - Out of mode, enable with an address that is not 4 KB aligned, or that has a bit set at or above `PA_W` (40), or with `cmd_rev` different from `REV_ID` gives fail-invalid.
  - Otherwise enable gives OK, sets `mode_on`, makes the pointer all ones and remembers the address as the region address.
  - Enable while in mode fails generically with error 15.
- R6: Load pointer.
  - A badly formed address fails with error 9.
  - An address equal to the region address fails with error 10.
  - A revision mismatch fails with error 11.
  - Otherwise the pointer takes the address and the result is OK.
- R7: Store returns the current pointer on `rsp_data` (all ones when invalid) with OK. All other outcomes return `rsp_data`=0.
- R8: Clear.
  - A badly formed address fails with error 2.
  - An address equal to the region address fails with error 3.
  - Otherwise the addressed page's state becomes clear, and if the address equals the current pointer the pointer becomes all ones.
- R9: Launch and resume with an invalid pointer give fail-invalid. With a valid pointer and `cmd_ss_block`=1 they fail with error 26.
- R10: Launch state gates the two entry commands.
  - Launch fails with error 4 unless the pointer's page is clear; on success it marks the page launched.
  - Resume fails with error 5 unless the page is launched.
- R11: Launch-state table.
  - The table tracks 4 pages.
  - Clear and successful launch allocate an entry on a miss, evicting the oldest entry when the table is full.
  - An untracked page is treated as clear.
- R12: After the state checks pass, `cmd_entry_ok`=0 fails with error 7 and leaves the launch state unchanged.
- R13: Disable gives OK and clears `mode_on`, after which every command other than enable is undefined-opcode.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 64 | Operand physical address |
| cmd_cpl | input | 2 | Current privilege level |
| cmd_legacy | input | 1 | Core in a mode that does not recognise the commands |
| cmd_nonroot | input | 1 | Core running a guest |
| cmd_feat_en | input | 1 | Virtualization feature enabled by control register |
| cmd_rev | input | 32 | Revision word read at the operand address |
| cmd_ss_block | input | 1 | Events blocked by a preceding stack-segment load |
| cmd_entry_ok | input | 1 | External entry consistency checks passed |
| rsp_valid | output | 1 | Result valid |
| rsp_code | output | 3 | Outcome code |
| rsp_flags | output | 6 | Arithmetic flag vector |
| rsp_data | output | 64 | Stored pointer for the store command |
| err_field | output | 8 | Last fail-valid error number |
| mode_on | output | 1 | Virtualization mode active |

## Verification

On every cycle, the assertions check:

- the one-cycle response timing;
- that each outcome code carries its flag vector;
- that fail-valid never appears while the pointer is the all-ones sentinel;
- that the error field moves only on fail-valid;
- that the three fault outcomes win over a low privilege level as the priority order demands;
- that a successful enable leaves the sentinel in the pointer.

Only the bench's command sequences can show the behaviour that depends on history:

- the clear/launched progression of a page;
- invalidation of the pointer by clear;
- forgetting an evicted page once a fifth page arrives;
- the exact error number chosen among several failing checks.

// File: rtl/vcsp_pkg.sv
package vcsp_pkg;

  typedef enum logic [2:0] {
    OP_ENABLE  = 3'd0,
    OP_DISABLE = 3'd1,
    OP_LOAD    = 3'd2,
    OP_STORE   = 3'd3,
    OP_CLEAR   = 3'd4,
    OP_LAUNCH  = 3'd5,
    OP_RESUME  = 3'd6,
    OP_RSVD    = 3'd7
  } vcsp_op_e;

  typedef enum logic [2:0] {
    RC_OK       = 3'd0,
    RC_FAIL_INV = 3'd1,
    RC_FAIL_VAL = 3'd2,
    RC_UD       = 3'd3,
    RC_GP       = 3'd4,
    RC_EXIT     = 3'd5
  } vcsp_rc_e;

  localparam logic [7:0] ERR_CLR_ADDR     = 8'd2;
  localparam logic [7:0] ERR_CLR_REGION   = 8'd3;
  localparam logic [7:0] ERR_LAUNCH_STATE = 8'd4;
  localparam logic [7:0] ERR_RESUME_STATE = 8'd5;
  localparam logic [7:0] ERR_ENTRY_CHK    = 8'd7;
  localparam logic [7:0] ERR_LD_ADDR      = 8'd9;
  localparam logic [7:0] ERR_LD_REGION    = 8'd10;
  localparam logic [7:0] ERR_LD_REV       = 8'd11;
  localparam logic [7:0] ERR_ENABLE_AGAIN = 8'd15;
  localparam logic [7:0] ERR_SS_BLOCK     = 8'd26;

  // flag vector bit order: {OF, SF, ZF, AF, PF, CF}
  function automatic logic [5:0] rc_flags(input vcsp_rc_e rc);
    case (rc)
      RC_FAIL_INV: return 6'b000001;
      RC_FAIL_VAL: return 6'b001000;
      default:     return 6'b000000;
    endcase
  endfunction

endpackage

// File: rtl/vcsp_addr_chk.sv
module vcsp_addr_chk #(
  parameter int PA_W = 40
) (
  input  logic [63:0] addr,
  input  logic [63:0] region,
  output logic        bad_form,
  output logic        is_region
);
  localparam int PAGE_BITS = 12;

  assign bad_form  = (|addr[PAGE_BITS-1:0]) | (|addr[63:PA_W]);
  assign is_region = (addr == region);
endmodule

// File: rtl/vcsp_launch_tbl.sv
module vcsp_launch_tbl #(
  parameter int NENT  = 4,
  parameter int TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] tag,
  input  logic             wr_en,
  input  logic             wr_launched,
  output logic             hit,
  output logic             hit_launched
);
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;

  logic [NENT-1:0]  vld_q;
  logic [NENT-1:0]  lch_q;
  logic [TAG_W-1:0] tag_q [NENT];
  logic [IW-1:0]    rr_q;
  logic [NENT-1:0]  match;
  logic             have_free;
  logic [IW-1:0]    free_idx;
  logic [IW-1:0]    victim;

  for (genvar i = 0; i < NENT; i++) begin : g_match
    assign match[i] = vld_q[i] && (tag_q[i] == tag);
  end

  assign hit          = |match;
  assign hit_launched = |(match & lch_q);

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        have_free = 1'b1;
        free_idx  = IW'(i);
      end
    end
    victim = have_free ? free_idx : rr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      lch_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < NENT; i++) tag_q[i] <= '0;
    end else if (wr_en) begin
      if (hit) begin
        for (int i = 0; i < NENT; i++)
          if (match[i]) lch_q[i] <= wr_launched;
      end else begin
        vld_q[victim] <= 1'b1;
        tag_q[victim] <= tag;
        lch_q[victim] <= wr_launched;
        if (!have_free)
          rr_q <= (rr_q == IW'(NENT - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vcsp_ctrl.sv
module vcsp_ctrl
  import vcsp_pkg::*;
#(
  parameter int          PA_W   = 40,
  parameter logic [31:0] REV_ID = 32'h0000_0011,
  parameter int          NENT   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [63:0] cmd_addr,
  input  logic [1:0]  cmd_cpl,
  input  logic        cmd_legacy,
  input  logic        cmd_nonroot,
  input  logic        cmd_feat_en,
  input  logic [31:0] cmd_rev,
  input  logic        cmd_ss_block,
  input  logic        cmd_entry_ok,
  output logic        rsp_valid,
  output logic [2:0]  rsp_code,
  output logic [5:0]  rsp_flags,
  output logic [63:0] rsp_data,
  output logic [7:0]  err_field,
  output logic        mode_on
);
  localparam int TAG_W = PA_W - 12;

  logic        mode_q, mode_nxt;
  logic [63:0] ptr_q, ptr_nxt;
  logic [63:0] region_q, region_nxt;
  logic [7:0]  err_q;
  logic        ptr_valid;
  logic        a_bad, a_region;
  logic        tbl_hit, tbl_launched, tbl_we, tbl_set;
  logic [TAG_W-1:0] tbl_tag;
  logic        do_fail;
  logic [7:0]  fail_code;
  logic [63:0] data_nxt;
  vcsp_op_e    op;
  vcsp_rc_e    rc;

  assign op        = vcsp_op_e'(cmd_op);
  assign ptr_valid = ~&ptr_q;
  assign tbl_tag   = (op == OP_CLEAR) ? cmd_addr[PA_W-1:12] : ptr_q[PA_W-1:12];

  vcsp_addr_chk #(.PA_W(PA_W)) u_addr (
    .addr(cmd_addr), .region(region_q), .bad_form(a_bad), .is_region(a_region)
  );

  vcsp_launch_tbl #(.NENT(NENT), .TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .tag(tbl_tag), .wr_en(tbl_we),
    .wr_launched(tbl_set), .hit(tbl_hit), .hit_launched(tbl_launched)
  );

  always_comb begin
    rc         = RC_OK;
    do_fail    = 1'b0;
    fail_code  = '0;
    mode_nxt   = mode_q;
    ptr_nxt    = ptr_q;
    region_nxt = region_q;
    tbl_we     = 1'b0;
    tbl_set    = 1'b0;
    data_nxt   = '0;
    if (op == OP_RSVD || cmd_legacy || ((op == OP_ENABLE) ? !cmd_feat_en : !mode_q))
      rc = RC_UD;
    else if (mode_q && cmd_nonroot)
      rc = RC_EXIT;
    else if (cmd_cpl != 2'd0)
      rc = RC_GP;
    else begin
      case (op)
        OP_ENABLE: begin
          if (mode_q) begin
            do_fail = 1'b1; fail_code = ERR_ENABLE_AGAIN;
          end else if (a_bad || cmd_rev != REV_ID) begin
            rc = RC_FAIL_INV;
          end else begin
            mode_nxt = 1'b1; ptr_nxt = '1; region_nxt = cmd_addr;
          end
        end
        OP_DISABLE: mode_nxt = 1'b0;
        OP_LOAD: begin
          if (a_bad)                  begin do_fail = 1'b1; fail_code = ERR_LD_ADDR;   end
          else if (a_region)          begin do_fail = 1'b1; fail_code = ERR_LD_REGION; end
          else if (cmd_rev != REV_ID) begin do_fail = 1'b1; fail_code = ERR_LD_REV;    end
          else ptr_nxt = cmd_addr;
        end
        OP_STORE: data_nxt = ptr_q;
        OP_CLEAR: begin
          if (a_bad)         begin do_fail = 1'b1; fail_code = ERR_CLR_ADDR;   end
          else if (a_region) begin do_fail = 1'b1; fail_code = ERR_CLR_REGION; end
          else begin
            tbl_we = 1'b1;
            if (cmd_addr == ptr_q) ptr_nxt = '1;
          end
        end
        default: begin // launch and resume
          if (!ptr_valid) rc = RC_FAIL_INV;
          else if (cmd_ss_block) begin do_fail = 1'b1; fail_code = ERR_SS_BLOCK; end
          else if (op == OP_LAUNCH && tbl_launched) begin
            do_fail = 1'b1; fail_code = ERR_LAUNCH_STATE;
          end else if (op == OP_RESUME && !tbl_launched) begin
            do_fail = 1'b1; fail_code = ERR_RESUME_STATE;
          end else if (!cmd_entry_ok) begin
            do_fail = 1'b1; fail_code = ERR_ENTRY_CHK;
          end else if (op == OP_LAUNCH) begin
            tbl_we = 1'b1; tbl_set = 1'b1;
          end
        end
      endcase
      if (do_fail) rc = ptr_valid ? RC_FAIL_VAL : RC_FAIL_INV;
    end
    if (!cmd_valid) tbl_we = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      ptr_q     <= '1;
      region_q  <= '0;
      err_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rsp_flags <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        mode_q    <= mode_nxt;
        ptr_q     <= ptr_nxt;
        region_q  <= region_nxt;
        rsp_code  <= rc;
        rsp_flags <= rc_flags(rc);
        rsp_data  <= data_nxt;
        if (rc == RC_FAIL_VAL) err_q <= fail_code;
      end
    end
  end

  assign err_field = err_q;
  assign mode_on   = mode_q;
endmodule

// File: rtl/vcsp_ctrl_chk.sv
module vcsp_ctrl_chk
  import vcsp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic [1:0]  cmd_cpl,
  input logic        cmd_legacy,
  input logic        cmd_nonroot,
  input logic        mode_on,
  input logic [63:0] cur_ptr,
  input logic        rsp_valid,
  input logic [2:0]  rsp_code,
  input logic [5:0]  rsp_flags,
  input logic [7:0]  err_field
);
  logic ordinary_op;
  assign ordinary_op = (cmd_op != OP_ENABLE) && (cmd_op != OP_RSVD);

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  assert_ud_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_legacy |=> rsp_code == RC_UD);
  assert_exit_over_gp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && mode_on && cmd_nonroot && !cmd_legacy && ordinary_op |=> rsp_code == RC_EXIT);
  assert_gp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && mode_on && !cmd_nonroot && !cmd_legacy && ordinary_op && cmd_cpl != 2'd0
    |=> rsp_code == RC_GP);
  assert_flags_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == RC_OK |-> rsp_flags == 6'b000000);
  assert_flags_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == RC_FAIL_INV |-> rsp_flags == 6'b000001);
  assert_flags_val_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == RC_FAIL_VAL |-> rsp_flags == 6'b001000);
  assert_fv_needs_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (&cur_ptr) |=> rsp_code != RC_FAIL_VAL);
  assert_err_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_code == RC_FAIL_VAL) |-> $stable(err_field));
  assert_enable_sentinel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == RC_OK && $past(cmd_op) == OP_ENABLE |-> (&cur_ptr) && mode_on);
endmodule

bind vcsp_ctrl vcsp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_cpl(cmd_cpl), .cmd_legacy(cmd_legacy), .cmd_nonroot(cmd_nonroot),
  .mode_on(mode_on), .cur_ptr(ptr_q), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .rsp_flags(rsp_flags), .err_field(err_field)
);

// File: tb/vcsp_ctrl_test.sv
module vcsp_ctrl_test;
  localparam logic [31:0] REV = 32'h0000_0011;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [63:0] cmd_addr = '0;
  logic [1:0]  cmd_cpl = '0;
  logic        cmd_legacy = 1'b0, cmd_nonroot = 1'b0, cmd_feat_en = 1'b1;
  logic [31:0] cmd_rev = '0;
  logic        cmd_ss_block = 1'b0, cmd_entry_ok = 1'b1;
  logic        rsp_valid, mode_on;
  logic [2:0]  rsp_code;
  logic [5:0]  rsp_flags;
  logic [63:0] rsp_data;
  logic [7:0]  err_field;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  logic        m_mode = 0;
  logic [63:0] m_ptr = ONES;
  logic [63:0] m_region = 0;
  logic [7:0]  m_err = 0;
  logic [27:0] m_tags[$];
  bit          m_lch[$];

  always #10 clk = ~clk;

  vcsp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_cpl(cmd_cpl), .cmd_legacy(cmd_legacy),
    .cmd_nonroot(cmd_nonroot), .cmd_feat_en(cmd_feat_en), .cmd_rev(cmd_rev),
    .cmd_ss_block(cmd_ss_block), .cmd_entry_ok(cmd_entry_ok),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_flags(rsp_flags),
    .rsp_data(rsp_data), .err_field(err_field), .mode_on(mode_on)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int find_tag(logic [27:0] t);
    foreach (m_tags[i]) if (m_tags[i] == t) return i;
    return -1;
  endfunction

  task automatic tbl_write(logic [27:0] t, bit l);
    int idx = find_tag(t);
    if (idx >= 0) m_lch[idx] = l;
    else begin
      if (m_tags.size() == 4) begin
        void'(m_tags.pop_front());
        void'(m_lch.pop_front());
      end
      m_tags.push_back(t);
      m_lch.push_back(l);
    end
  endtask

  // behavioural reference: returns outcome code and data, updates model state
  task automatic model(input int op, input logic [63:0] a, input int cpl, input bit leg,
                       input bit nr, input bit fe, input logic [31:0] rv, input bit ss,
                       input bit eok, output int rc, output logic [63:0] data);
    bit bad = (a[11:0] != 0) || ((a >> 40) != 0);
    bit pv  = (m_ptr != ONES);
    int fe_code = -1;
    data = 0;
    rc = 0;
    if (op == 7 || leg || (op == 0 && !fe) || (op != 0 && !m_mode)) begin rc = 3; return; end
    if (m_mode && nr) begin rc = 5; return; end
    if (cpl != 0) begin rc = 4; return; end
    if (op == 0) begin
      if (m_mode) fe_code = 15;
      else if (bad || rv != REV) begin rc = 1; return; end
      else begin m_mode = 1; m_ptr = ONES; m_region = a; end
    end else if (op == 1) m_mode = 0;
    else if (op == 2) begin
      if (bad) fe_code = 9;
      else if (a == m_region) fe_code = 10;
      else if (rv != REV) fe_code = 11;
      else m_ptr = a;
    end else if (op == 3) data = m_ptr;
    else if (op == 4) begin
      if (bad) fe_code = 2;
      else if (a == m_region) fe_code = 3;
      else begin
        tbl_write(a[39:12], 0);
        if (a == m_ptr) m_ptr = ONES;
      end
    end else begin
      int idx = find_tag(m_ptr[39:12]);
      bit launched = (idx >= 0) ? m_lch[idx] : 0;
      if (!pv) begin rc = 1; return; end
      if (ss) fe_code = 26;
      else if (op == 5 && launched) fe_code = 4;
      else if (op == 6 && !launched) fe_code = 5;
      else if (!eok) fe_code = 7;
      else if (op == 5) tbl_write(m_ptr[39:12], 1);
    end
    if (fe_code >= 0) begin
      if (pv) begin rc = 2; m_err = fe_code[7:0]; end
      else rc = 1;
    end
  endtask

  task automatic cmd(string req, int op, logic [63:0] a, int cpl = 0, bit leg = 0,
                     bit nr = 0, bit fe = 1, logic [31:0] rv = REV, bit ss = 0, bit eok = 1);
    int erc;
    logic [63:0] edata;
    logic [5:0] eflags;
    model(op, a, cpl, leg, nr, fe, rv, ss, eok, erc, edata);
    eflags = (erc == 1) ? 6'b000001 : (erc == 2) ? 6'b001000 : 6'b000000;
    cmd_op = op[2:0]; cmd_addr = a; cmd_cpl = cpl[1:0]; cmd_legacy = leg;
    cmd_nonroot = nr; cmd_feat_en = fe; cmd_rev = rv; cmd_ss_block = ss;
    cmd_entry_ok = eok; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(req, "rsp_code", 64'(rsp_code), 64'(erc));
    chk("R3", "rsp_flags", 64'(rsp_flags), 64'(eflags));
    chk("R7", "rsp_data", rsp_data, edata);
    chk("R4", "err_field", 64'(err_field), 64'(m_err));
    chk("R13", "mode_on", 64'(mode_on), 64'(m_mode));
    @(negedge clk);
    chk("R1", "rsp_valid idle", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "reset mode_on", 64'(mode_on), 64'd0);
    chk("R1", "reset err_field", 64'(err_field), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmd("R13", 2, 64'h2000);                  // not in mode
    cmd("R2", 0, 64'h1000, 0, 0, 0, 0);       // feature disabled
    cmd("R5", 0, 64'h1004);                   // misaligned
    cmd("R5", 0, 64'h1000, 0, 0, 0, 1, 32'h5);// bad revision
    cmd("R5", 0, 64'h1000);                   // success
    cmd("R7", 3, 0);
    cmd("R9", 5, 0);                          // invalid pointer
    cmd("R4", 0, 64'h1000);                   // enable again, no pointer
    cmd("R6", 2, 64'h2008);
    cmd("R6", 2, 64'h1000);
    cmd("R6", 2, 64'h2000, 0, 0, 0, 1, 32'h99);
    cmd("R6", 2, 64'h2000);
    cmd("R7", 3, 0);
    cmd("R6", 2, 64'h100_0000_3000);          // above width, pointer valid
    cmd("R5", 0, 64'h1000);                   // enable again, err 15
    cmd("R2", 3, 0, 3, 1, 1);                 // undefined wins
    cmd("R2", 3, 0, 3, 0, 1);                 // exit wins over privilege
    cmd("R2", 3, 0, 3);                       // privilege fault
    cmd("R2", 7, 0);                          // reserved
    cmd("R10", 6, 0);                         // resume untracked
    cmd("R9", 5, 0, 0, 0, 0, 1, REV, 1);      // ss blocked
    cmd("R12", 5, 0, 0, 0, 0, 1, REV, 0, 0);  // entry checks fail
    cmd("R12", 6, 0);                         // still clear
    cmd("R10", 5, 0);
    cmd("R10", 5, 0);
    cmd("R10", 6, 0);
    cmd("R8", 4, 64'h2000);                   // invalidates pointer
    cmd("R8", 3, 0);
    cmd("R6", 2, 64'h2000);
    cmd("R8", 6, 0);                          // cleared state
    cmd("R10", 5, 0);
    cmd("R8", 4, 64'h3001);
    cmd("R8", 4, 64'h1000);
    cmd("R11", 4, 64'h3000);
    cmd("R11", 4, 64'h4000);
    cmd("R11", 4, 64'h5000);
    cmd("R11", 6, 0);                         // 0x2000 still launched
    cmd("R11", 4, 64'h6000);                  // evicts 0x2000
    cmd("R11", 6, 0);                         // forgotten, treated clear
    cmd("R11", 5, 0);
    cmd("R13", 1, 0);
    cmd("R13", 3, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule